// File: doc/BRIEF.md
# CAN Receive Buffer Acceptance Control

This block holds the control and status state of a single CAN receive buffer. An upstream receiver presents each decoded frame with a one-cycle `frm_done` strobe. Alongside the strobe it gives an error-free flag, an extended-identifier flag, a remote-request flag and the number of the acceptance filter that matched. The block decides whether the frame belongs in this buffer and whether the programmed mode admits it. When the frame is admitted, the block records its remote-request flag and filter number and marks the buffer full.

Software reaches the block through a byte-wide status port and a write strobe. The port shows the full flag, the mode, the remote-request flag and the filter number. A write sets the mode, and writing 0 to the full-flag bit releases the buffer. While the buffer is full, any further frame that would have been admitted is dropped, and an overflow pulse is raised for that frame.

Top module: `can_rxbuf_ctrl`

## Requirements
- R1: After reset `sw_rdata` reads 8'h00 and `ovf_pulse` is 0.
- R2: With mode 2'b00 a frame is admitted when `frm_ok` is 1, whatever `frm_ext` is, and is rejected when `frm_ok` is 0.
- R3: With mode 2'b01 a frame is admitted only when `frm_ok`=1 and `frm_ext`=0.
- R4: With mode 2'b10 a frame is admitted only when `frm_ok`=1 and `frm_ext`=1.
- R5: With mode 2'b11 every frame is admitted, including frames with `frm_ok`=0.
- R6: Filter numbers 2 to 5 are always routed to this buffer. Numbers 0 and 1 are routed only while `rollover_en`=1. Numbers 6 and 7 are reserved and never routed. A frame that is not routed changes nothing.
- R7: Status byte layout: bit 7 is the full flag, bits 6:5 the mode, bit 4 always 0, bit 3 the remote-request flag of the last stored frame, and bits 2:0 its filter number. On admission the full flag becomes 1 and bits 3:0 are updated in the cycle after the strobe. At no other time do bits 3:0 change.
- R8: While the full flag is 1, a frame that would be admitted is not stored. Bits 3:0 keep their value, and `ovf_pulse` is 1 for exactly the one cycle after that frame's strobe.
- R9: A write with bit 7 = 0 clears the full flag. If the same cycle also carries a strobe, the clear acts first and the frame is admitted. The mode used for a frame is the one held before any write in the same cycle.
- R10: A write loads bits 6:5 into the mode. Written bits 4:0 are ignored, and writing 1 to bit 7 never sets the full flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | One-cycle strobe: frame decoded |
| frm_ok | input | 1 | Frame has no errors |
| frm_ext | input | 1 | Frame uses an extended identifier |
| frm_rtr | input | 1 | Frame is a remote transfer request |
| frm_filt | input | 3 | Number of the acceptance filter that matched |
| rollover_en | input | 1 | Route filters 0 and 1 to this buffer |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Status byte |
| ovf_pulse | output | 1 | One-cycle pulse: frame dropped because buffer full |

## Verification
The hardest case to reach is a full-flag clear that lands in the same clock cycle as a frame strobe, especially when the same write also changes the mode. The bench drives the write and the strobe on the same edge while the buffer is full. It checks that the frame is admitted under the old mode and that no overflow pulse appears. It also sends frames to a full buffer and confirms that the stored fields do not move, and it steps filter numbers 0, 1, 6 and 7 with `rollover_en` low and high.

// File: rtl/can_rxbuf_pkg.sv
package can_rxbuf_pkg;

    localparam int STAT_W  = 8;
    localparam int FILT_W  = 3;
    localparam int MODE_W  = 2;

    localparam int BIT_FULL = 7;
    localparam int BIT_MODE = 5;
    localparam int BIT_RSVD = 4;
    localparam int BIT_RTR  = 3;
    localparam int BIT_FILT = 0;

    typedef enum logic [MODE_W-1:0] {
        MODE_VALID_ANY = 2'b00,
        MODE_VALID_STD = 2'b01,
        MODE_VALID_EXT = 2'b10,
        MODE_TAKE_ALL  = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic              full;
        rx_mode_e          mode;
        logic              rtr;
        logic [FILT_W-1:0] filt;
        logic              ovf;
    } rx_state_t;

    typedef struct packed {
        logic              clr_full;
        logic              mode_we;
        rx_mode_e          mode_new;
    } sw_cmd_t;

endpackage

// File: rtl/rxbuf_accept.sv
module rxbuf_accept
    import can_rxbuf_pkg::*;
#(
    parameter int NUM_FILT    = 6,
    parameter int SHARED_FILT = 2
) (
    input  rx_mode_e          mode,
    input  logic              ok,
    input  logic              ext,
    input  logic [FILT_W-1:0] filt,
    input  logic              rollover_en,
    output logic              routed,
    output logic              admit
);

    localparam int NUM_CODES = 1 << FILT_W;

    logic [NUM_CODES-1:0] route_vec;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_route
        if (g >= NUM_FILT) begin : g_rsvd
            assign route_vec[g] = 1'b0;
        end else if (g < SHARED_FILT) begin : g_shared
            assign route_vec[g] = rollover_en;
        end else begin : g_own
            assign route_vec[g] = 1'b1;
        end
    end

    logic mode_ok;

    always_comb begin
        unique case (mode)
            MODE_VALID_ANY: mode_ok = ok;
            MODE_VALID_STD: mode_ok = ok && !ext;
            MODE_VALID_EXT: mode_ok = ok && ext;
            default:        mode_ok = 1'b1;
        endcase
    end

    assign routed = route_vec[filt];
    assign admit  = routed && mode_ok;

endmodule

// File: rtl/rxbuf_swif.sv
module rxbuf_swif
    import can_rxbuf_pkg::*;
(
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  rx_state_t         st,
    output sw_cmd_t           cmd,
    output logic [STAT_W-1:0] rdata
);

    always_comb begin
        cmd.clr_full = wr && !wdata[BIT_FULL];
        cmd.mode_we  = wr;
        cmd.mode_new = rx_mode_e'(wdata[BIT_MODE +: MODE_W]);
    end

    always_comb begin
        rdata                       = '0;
        rdata[BIT_FULL]             = st.full;
        rdata[BIT_MODE +: MODE_W]   = st.mode;
        rdata[BIT_RSVD]             = 1'b0;
        rdata[BIT_RTR]              = st.rtr;
        rdata[BIT_FILT +: FILT_W]   = st.filt;
    end

endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status
    import can_rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              admit,
    input  logic              rtr,
    input  logic [FILT_W-1:0] filt,
    input  sw_cmd_t           cmd,
    output rx_state_t         st
);

    rx_state_t st_d, st_q;
    logic      full_eff;

    always_comb begin
        st_d     = st_q;
        full_eff = st_q.full && !cmd.clr_full;
        st_d.ovf = 1'b0;
        if (cmd.mode_we) begin
            st_d.mode = cmd.mode_new;
        end
        st_d.full = full_eff;
        if (done && admit) begin
            if (full_eff) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.full = 1'b1;
                st_d.rtr  = rtr;
                st_d.filt = filt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/can_rxbuf_ctrl.sv
module can_rxbuf_ctrl
    import can_rxbuf_pkg::*;
#(
    parameter int NUM_FILT    = 6,
    parameter int SHARED_FILT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_done,
    input  logic              frm_ok,
    input  logic              frm_ext,
    input  logic              frm_rtr,
    input  logic [FILT_W-1:0] frm_filt,
    input  logic              rollover_en,
    input  logic              sw_wr,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] sw_rdata,
    output logic              ovf_pulse
);

    rx_state_t st;
    sw_cmd_t   cmd;
    logic      routed;
    logic      admit;

    rxbuf_accept #(
        .NUM_FILT   (NUM_FILT),
        .SHARED_FILT(SHARED_FILT)
    ) u_accept (
        .mode       (st.mode),
        .ok         (frm_ok),
        .ext        (frm_ext),
        .filt       (frm_filt),
        .rollover_en(rollover_en),
        .routed     (routed),
        .admit      (admit)
    );

    rxbuf_swif u_swif (
        .wr   (sw_wr),
        .wdata(sw_wdata),
        .st   (st),
        .cmd  (cmd),
        .rdata(sw_rdata)
    );

    rxbuf_status u_status (
        .clk  (clk),
        .rst_n(rst_n),
        .done (frm_done),
        .admit(admit),
        .rtr  (frm_rtr),
        .filt (frm_filt),
        .cmd  (cmd),
        .st   (st)
    );

    assign ovf_pulse = st.ovf;

endmodule

// File: rtl/can_rxbuf_ctrl_chk.sv
module can_rxbuf_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_done,
    input logic [2:0] frm_filt,
    input logic       rollover_en,
    input logic       sw_wr,
    input logic [7:0] sw_rdata,
    input logic       ovf_pulse
);

    AST_BIT4_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rdata[4] == 1'b0); // R7

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_done) |-> $stable(sw_rdata[3:0])); // R7

    AST_FULL_ONLY_BY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_rdata[7]) |-> $past(frm_done)); // R10

    AST_NO_RESERVED_FILT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_rdata[7]) |-> sw_rdata[2:0] <= 3'd5); // R6

    AST_SHARED_NEEDS_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sw_rdata[7]) && sw_rdata[2:0] < 3'd2) |-> $past(rollover_en)); // R6

    AST_OVF_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ($stable(sw_rdata[3:0]) && sw_rdata[7] && $past(frm_done))); // R8

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_wr) |-> $stable(sw_rdata[6:5])); // R10

endmodule

bind can_rxbuf_ctrl can_rxbuf_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_done   (frm_done),
    .frm_filt   (frm_filt),
    .rollover_en(rollover_en),
    .sw_wr      (sw_wr),
    .sw_rdata   (sw_rdata),
    .ovf_pulse  (ovf_pulse)
);

// File: tb/can_rxbuf_ctrl_test.sv
`timescale 1ns/1ps
module can_rxbuf_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_done = 1'b0, frm_ok = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [2:0] frm_filt = '0;
    logic       rollover_en = 1'b0;
    logic       sw_wr = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic [7:0] sw_rdata;
    logic       ovf_pulse;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    can_rxbuf_ctrl uut (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_ok(frm_ok),
        .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_filt(frm_filt),
        .rollover_en(rollover_en), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .ovf_pulse(ovf_pulse)
    );

    // behavioural reference model
    int m_full = 0, m_mode = 0, m_rtr = 0, m_filt = 0, m_ovf = 0;

    always @(posedge clk) begin
        int clr, routed, okm, fe;
        if (!rst_n) begin
            m_full = 0; m_mode = 0; m_rtr = 0; m_filt = 0; m_ovf = 0;
        end else begin
            clr    = (sw_wr && !sw_wdata[7]) ? 1 : 0;
            routed = (frm_filt <= 5 && (frm_filt >= 2 || rollover_en)) ? 1 : 0;
            case (m_mode)
                0: okm = frm_ok;
                1: okm = frm_ok && !frm_ext;
                2: okm = frm_ok && frm_ext;
                default: okm = 1;
            endcase
            fe = (m_full && !clr) ? 1 : 0;
            m_ovf = 0;
            if (frm_done && routed && okm) begin
                if (fe) begin
                    m_ovf = 1;
                end else begin
                    fe = 1;
                    m_rtr = frm_rtr;
                    m_filt = frm_filt;
                end
            end
            m_full = fe;
            if (sw_wr) m_mode = sw_wdata[6:5];
        end
    end

    function automatic logic [7:0] model_byte();
        return {m_full[0], m_mode[1:0], 1'b0, m_rtr[0], m_filt[2:0]};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // advance one clock, then compare against the model
    task automatic tick();
        @(posedge clk);
        #1;
        chk("R7 model status", sw_rdata, model_byte());
        chk("R8 model overflow", {7'd0, ovf_pulse}, {7'd0, m_ovf[0]});
        frm_done = 0; sw_wr = 0;
    endtask

    task automatic frame(logic ok, logic ext, logic rtr, logic [2:0] f);
        frm_done = 1; frm_ok = ok; frm_ext = ext; frm_rtr = rtr; frm_filt = f;
    endtask

    task automatic wr(logic [7:0] d);
        sw_wr = 1; sw_wdata = d;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("R1 reset status", sw_rdata, 8'h00);
        chk("R1 reset ovf", {7'd0, ovf_pulse}, 8'h00);

        // R2 mode 00
        frame(0, 0, 1, 3'd3); tick();
        chk("R2 error frame rejected", sw_rdata, 8'h00);
        frame(1, 1, 1, 3'd3); tick();
        chk("R2 valid ext admitted", sw_rdata, 8'h8B);
        wr(8'h00); tick();
        chk("R9 clear full", sw_rdata, 8'h0B);

        // R3 mode 01
        wr(8'h20); tick();
        frame(1, 1, 0, 3'd4); tick();
        chk("R3 ext rejected", sw_rdata, 8'h2B);
        frame(1, 0, 0, 3'd4); tick();
        chk("R3 std admitted", sw_rdata, 8'hA4);
        wr(8'h40); tick();
        chk("R10 mode write with clear", sw_rdata, 8'h44);

        // R4 mode 10
        frame(1, 0, 1, 3'd5); tick();
        chk("R4 std rejected", sw_rdata, 8'h44);
        frame(0, 1, 1, 3'd5); tick();
        chk("R4 error ext rejected", sw_rdata, 8'h44);
        frame(1, 1, 1, 3'd5); tick();
        chk("R4 valid ext admitted", sw_rdata, 8'hCD);

        // R8 overflow while full
        frame(1, 1, 0, 3'd2); @(posedge clk); #1;
        chk("R8 ovf pulse", {7'd0, ovf_pulse}, 8'h01);
        chk("R8 fields kept", sw_rdata, 8'hCD);
        frm_done = 0; tick();
        chk("R8 ovf one cycle", {7'd0, ovf_pulse}, 8'h00);

        // R9 clear and frame in the same cycle, with mode change to 11
        wr(8'h60); frame(1, 1, 0, 3'd2); tick();
        chk("R9 clear+frame admitted", sw_rdata, 8'hE2);
        chk("R9 no overflow", {7'd0, ovf_pulse}, 8'h00);

        // R10 writing 1 to full bit and junk in low bits
        wr(8'h7F); tick();
        chk("R10 clear via bit7=0, low bits ignored", sw_rdata, 8'h62);
        wr(8'hFF); tick();
        chk("R10 bit7=1 does not set full", sw_rdata, 8'h62);

        // R5 mode 11 accepts error frames
        frame(0, 0, 1, 3'd3); tick();
        chk("R5 error frame admitted", sw_rdata, 8'hEB);
        wr(8'h60); tick();

        // R6 routing
        frame(1, 0, 0, 3'd0); tick();
        chk("R6 filt0 no rollover", sw_rdata, 8'h6B);
        frame(1, 0, 0, 3'd6); tick();
        chk("R6 filt6 reserved", sw_rdata, 8'h6B);
        rollover_en = 1;
        frame(1, 0, 0, 3'd7); tick();
        chk("R6 filt7 reserved", sw_rdata, 8'h6B);
        frame(1, 0, 1, 3'd1); tick();
        chk("R6 filt1 with rollover", sw_rdata, 8'hE9);
        wr(8'h60); tick();
        frame(1, 0, 0, 3'd0); tick();
        chk("R6 filt0 with rollover", sw_rdata, 8'hE0);

        // sweep with model comparison
        for (int i = 0; i < 200; i++) begin
            if (i % 3 == 0) frame(i[0], i[1], i[2], i[5:3]);
            if (i % 5 == 0) wr({i[3], i[5:4], 5'h1F});
            rollover_en = i[6];
            tick();
        end

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule